// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a stereo PCM bit stream into parallel samples. It runs on the serial bit clock. It watches a word clock and a data line and rebuilds one left and one right sample per stereo frame. One receiver covers four common framing conventions. These differ in which word-clock level marks the left channel, in whether the first data bit follows the word-clock change at once or one bit later, in which bit-clock edge samples the data, and in whether words are aligned to the start or the end of their slot. A short high pulse framing, as used by DSP serial ports, is also supported.

The framing and the sample length (16 or 18 bits) are taken from two static inputs once, just after reset. When a complete pair has been received, both 18-bit two's-complement samples are presented together with a strobe that is high for one bit-clock cycle. A 16-bit word is sign-extended to 18 bits.

Top module: `pcm_serial_rx`

## Requirements
- R1: While reset is asserted and until the first pair completes, `valid_o` is 0 and both sample outputs are 0.
- R2: With `fmt_i` = 0 (I2S), word clock low marks the left slot and high marks the right slot. The bit that is present in the first bit period after a word-clock change is discarded. The word's MSB is the next bit. Data is sampled on the rising bit-clock edge.
- R3: With `fmt_i` = 1 (left-aligned), word clock high marks the left slot. The MSB is the bit present in the first bit period after a word-clock change. Data is sampled on the rising edge.
- R4: With `fmt_i` = 2 (right-aligned), word clock high marks the left slot. The word is the last N bits before the next word-clock change, where N is the word length. Bits earlier in the slot are discarded. Data is sampled on the rising edge.
- R5: The right-aligned format with 16-bit words and 16 bit clocks per slot (32 per frame) decodes correctly. Here the MSB follows one word-clock change and the LSB comes right before the next.
- R6: With `fmt_i` = 3 (pulse framing), data and word clock are sampled on the falling bit-clock edge. The MSB is the first bit after a high word-clock pulse of one or more bit periods returns low. The first pulse after reset opens a left word, and later pulses alternate right, left, and so on.
- R7: `wlen_long_i` = 1 selects 18-bit words and 0 selects 16-bit words in every format. Slot bits beyond the word are ignored.
- R8: 16-bit words appear on the outputs sign-extended to 18 bits. 18-bit words appear unchanged.
- R9: `valid_o` is high for exactly one cycle. That cycle follows the rising edge that processes the right word's LSB. `left_o` and `right_o` change only in that cycle, and both belong to the same frame.
- R10: `fmt_i` and `wlen_long_i` are captured on the first rising edge after reset is released. Later changes have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Serial bit clock; all state is clocked by it |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lrck_i | input | 1 | Word (frame) clock |
| sdata_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 2 | Framing: 0 I2S, 1 left-aligned, 2 right-aligned, 3 pulse |
| wlen_long_i | input | 1 | 1 = 18-bit words, 0 = 16-bit words |
| left_o | output | 18 | Left sample, two's complement |
| right_o | output | 18 | Right sample, two's complement |
| valid_o | output | 1 | One-cycle strobe: a new pair is on the outputs |

## Verification
The bench builds the receiver with its default parameters: an 18-bit output and a 6-bit slot counter. That counter covers slots of up to 63 bits, so 32-bit I2S slots and 24-bit padded slots are well within range. In pulse framing the bench corrupts the data line after each falling edge to prove falling-edge sampling. Slot lengths range from exactly one word (packed) up to twice a word, and both extreme values of each word length are sent.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

    localparam int SAMPLE_W = 18;
    localparam int SHORT_W  = 16;

    typedef enum logic [1:0] {
        FMT_I2S   = 2'd0,
        FMT_LEFT  = 2'd1,
        FMT_RIGHT = 2'd2,
        FMT_PULSE = 2'd3
    } fmt_e;

    // Widen a received word to the output width.
    function automatic logic [SAMPLE_W-1:0] widen(input logic [SAMPLE_W-1:0] raw,
                                                  input logic long_w);
        logic [SAMPLE_W-1:0] r;
        if (long_w) r = raw;
        else        r = {{(SAMPLE_W-SHORT_W){raw[SHORT_W-1]}}, raw[SHORT_W-1:0]};
        return r;
    endfunction

endpackage

// File: rtl/psr_edge_capture.sv
// Captures word clock and data on the falling edge for pulse framing;
// the other framings use the line values at the rising edge directly.
module psr_edge_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_fall,
    input  logic lr_i,
    input  logic sd_i,
    output logic lr_o,
    output logic sd_o
);

    logic lr_fall_q;
    logic sd_fall_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lr_fall_q <= 1'b0;
            sd_fall_q <= 1'b0;
        end else begin
            lr_fall_q <= lr_i;
            sd_fall_q <= sd_i;
        end
    end

    assign lr_o = sel_fall ? lr_fall_q : lr_i;
    assign sd_o = sel_fall ? sd_fall_q : sd_i;

endmodule

// File: rtl/psr_framer.sv
// Tracks slot boundaries, slot channel and bit position within the slot.
module psr_framer
    import pcm_rx_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fmt_e             fmt,
    input  logic             lr,
    output logic             start_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ch_o,
    output logic             active_o,
    output logic             prev_ch_o,
    output logic             prev_active_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             prev_lr;
        logic             seen;
        logic [CNT_W-1:0] cnt;
        logic             next_right;
        logic             ch;
        logic             active;
    } frm_state_t;

    frm_state_t frm_q, frm_d;
    logic       edge_s;
    logic       start_s;
    logic       new_ch;

    always_comb begin
        frm_d         = frm_q;
        frm_d.prev_lr = lr;
        frm_d.seen    = 1'b1;
        edge_s        = frm_q.seen && (lr != frm_q.prev_lr);
        start_s       = (fmt == FMT_PULSE) ? (edge_s && !lr) : edge_s;
        case (fmt)
            FMT_I2S:   new_ch = lr;
            FMT_PULSE: new_ch = frm_q.next_right;
            default:   new_ch = !lr;
        endcase
        if (start_s) begin
            frm_d.cnt    = '0;
            frm_d.ch     = new_ch;
            frm_d.active = 1'b1;
            if (fmt == FMT_PULSE) frm_d.next_right = !frm_q.next_right;
        end else if (frm_q.cnt != CNT_MAX) begin
            frm_d.cnt = frm_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) frm_q <= '0;
        else        frm_q <= frm_d;
    end

    assign start_o       = start_s;
    assign cnt_o         = frm_d.cnt;
    assign ch_o          = frm_d.ch;
    assign active_o      = frm_d.active;
    assign prev_ch_o     = frm_q.ch;
    assign prev_active_o = frm_q.active;

endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
    import pcm_rx_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic                bclk_i,
    input  logic                rst_ni,
    input  logic                lrck_i,
    input  logic                sdata_i,
    input  logic [1:0]          fmt_i,
    input  logic                wlen_long_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);

    localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(SAMPLE_W);
    localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(SHORT_W);

    typedef struct packed {
        fmt_e                fmt;
        logic                long_w;
        logic                cfg_done;
        logic [SAMPLE_W-1:0] sh;
        logic [SAMPLE_W-1:0] hold_l;
        logic                have_l;
        logic [SAMPLE_W-1:0] out_l;
        logic [SAMPLE_W-1:0] out_r;
        logic                valid;
    } rx_state_t;

    rx_state_t q, d;

    fmt_e             eff_fmt;
    logic             eff_long;
    logic             lr_s, bit_s;
    logic             f_start, f_ch, f_active, f_prev_ch, f_prev_active;
    logic [CNT_W-1:0] f_cnt;
    logic [CNT_W-1:0] delay;
    logic [CNT_W-1:0] n_len;
    logic [CNT_W-1:0] idx;
    logic             commit, commit_right;
    logic [SAMPLE_W-1:0] commit_val;

    // Configuration seen by the datapath: live inputs until captured.
    assign eff_fmt  = q.cfg_done ? q.fmt    : fmt_e'(fmt_i);
    assign eff_long = q.cfg_done ? q.long_w : wlen_long_i;

    psr_edge_capture cap_i (
        .clk      (bclk_i),
        .rst_n    (rst_ni),
        .sel_fall (eff_fmt == FMT_PULSE),
        .lr_i     (lrck_i),
        .sd_i     (sdata_i),
        .lr_o     (lr_s),
        .sd_o     (bit_s)
    );

    psr_framer #(.CNT_W(CNT_W)) frm_i (
        .clk           (bclk_i),
        .rst_n         (rst_ni),
        .fmt           (eff_fmt),
        .lr            (lr_s),
        .start_o       (f_start),
        .cnt_o         (f_cnt),
        .ch_o          (f_ch),
        .active_o      (f_active),
        .prev_ch_o     (f_prev_ch),
        .prev_active_o (f_prev_active)
    );

    assign delay = (eff_fmt == FMT_I2S) ? CNT_W'(1) : '0;
    assign n_len = eff_long ? LEN_LONG : LEN_SHORT;
    assign idx   = f_cnt - delay;

    always_comb begin
        d            = q;
        d.valid      = 1'b0;
        commit       = 1'b0;
        commit_right = 1'b0;
        commit_val   = '0;
        if (!q.cfg_done) begin
            d.fmt      = fmt_e'(fmt_i);
            d.long_w   = wlen_long_i;
            d.cfg_done = 1'b1;
        end
        if (eff_fmt == FMT_RIGHT) begin
            // Word ends at the boundary: keep the newest bits only.
            if (f_start && f_prev_active) begin
                commit       = 1'b1;
                commit_right = f_prev_ch;
                commit_val   = widen(q.sh, eff_long);
            end
            d.sh = {q.sh[SAMPLE_W-2:0], bit_s};
        end else if (f_active && (f_cnt >= delay) && (idx < n_len)) begin
            if (idx == '0) d.sh = {{(SAMPLE_W-1){1'b0}}, bit_s};
            else           d.sh = {q.sh[SAMPLE_W-2:0], bit_s};
            if (idx == n_len - 1'b1) begin
                commit       = 1'b1;
                commit_right = f_ch;
                commit_val   = widen(d.sh, eff_long);
            end
        end
        if (commit) begin
            if (!commit_right) begin
                d.hold_l = commit_val;
                d.have_l = 1'b1;
            end else if (q.have_l) begin
                d.out_l  = q.hold_l;
                d.out_r  = commit_val;
                d.valid  = 1'b1;
                d.have_l = 1'b0;
            end
        end
    end

    always_ff @(posedge bclk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    logic [1:0] cfg_fmt;
    logic       cfg_long;
    logic       cfg_done;
    assign cfg_fmt  = q.fmt;
    assign cfg_long = q.long_w;
    assign cfg_done = q.cfg_done;

    assign left_o  = q.out_l;
    assign right_o = q.out_r;
    assign valid_o = q.valid;

endmodule

// File: rtl/psr_checker.sv
module psr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        valid,
    input logic [17:0] left,
    input logic [17:0] right,
    input logic [1:0]  fmt_cfg,
    input logic        long_cfg,
    input logic        cfg_done
);

    // R1: quiet outputs while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!valid && left == '0 && right == '0);
        end
    end

    a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    a_r9_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> ($stable(left) && $stable(right)));

    a_r8_short_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !long_cfg) |-> (left[17:16] == {2{left[15]}} &&
                                  right[17:16] == {2{right[15]}}));

    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> ($stable(fmt_cfg) && $stable(long_cfg) && cfg_done));

endmodule

bind pcm_serial_rx psr_checker chk_i (
    .clk      (bclk_i),
    .rst_n    (rst_ni),
    .valid    (valid_o),
    .left     (left_o),
    .right    (right_o),
    .fmt_cfg  (cfg_fmt),
    .long_cfg (cfg_long),
    .cfg_done (cfg_done)
);

// File: tb/pcm_serial_rx_tb_top.sv
`timescale 1ns/1ps
module pcm_serial_rx_tb_top;

    logic        bclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lrck = 1'b0;
    logic        sdata = 1'b0;
    logic [1:0]  fmt = 2'd0;
    logic        wlong = 1'b0;
    logic [17:0] left_o, right_o;
    logic        valid_o;

    int n_chk = 0;
    int n_bad = 0;
    int n_got = 0;
    logic [17:0] got_l [8];
    logic [17:0] got_r [8];
    logic [17:0] tv_l  [8];
    logic [17:0] tv_r  [8];

    always #2 bclk = ~bclk;

    pcm_serial_rx dut_i (
        .bclk_i      (bclk),
        .rst_ni      (rst_n),
        .lrck_i      (lrck),
        .sdata_i     (sdata),
        .fmt_i       (fmt),
        .wlen_long_i (wlong),
        .left_o      (left_o),
        .right_o     (right_o),
        .valid_o     (valid_o)
    );

    // Record every delivered pair, sampled away from the rising edge.
    always @(negedge bclk) begin
        if (valid_o && n_got < 8) begin
            got_l[n_got] = left_o;
            got_r[n_got] = right_o;
        end
        if (valid_o) n_got = n_got + 1;
    end

    task automatic finish_up();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge bclk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete (act=hung exp=done)");
        finish_up();
    end

    task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [17:0] ext(input logic [17:0] w, input int n);
        if (n == 18) return w;
        return {{2{w[15]}}, w[15:0]};
    endfunction

    task automatic put(input logic lr, input logic sd, input logic glitch);
        @(posedge bclk); #1;
        lrck = lr; sdata = sd;
        if (glitch) begin
            @(negedge bclk); #1;
            sdata = ~sd;
        end
    endtask

    task automatic do_reset(input logic [1:0] f, input logic lg, input logic lr0);
        rst_n = 1'b0; fmt = f; wlong = lg; lrck = lr0; sdata = 1'b0;
        repeat (3) @(posedge bclk);
        #1 rst_n = 1'b1;
        n_got = 0;
    endtask

    // fm: 0 I2S, 1 left-aligned, 2 right-aligned; padding bits are 1.
    task automatic send_slot(input int fm, input int n, input int slot,
                             input logic lr, input logic [17:0] w);
        for (int p = 0; p < slot; p++) begin
            logic b;
            b = 1'b1;
            case (fm)
                0: if (p >= 1 && p <= n) b = w[n-p];
                1: if (p < n) b = w[n-1-p];
                default: if (p >= slot - n) b = w[slot-1-p];
            endcase
            put(lr, b, 1'b0);
        end
    endtask

    task automatic send_pulse_slot(input int n, input int pw, input int pad,
                                   input logic [17:0] w);
        for (int i = 0; i < pw; i++)  put(1'b1, 1'b1, 1'b1);
        for (int i = 0; i < n; i++)   put(1'b0, w[n-1-i], 1'b1);
        for (int i = 0; i < pad; i++) put(1'b0, 1'b1, 1'b1);
    endtask

    task automatic verify(input string tag, input int n, input int pairs);
        chk({tag, " pair count"}, 18'(n_got), 18'(pairs));
        for (int k = 0; k < pairs && k < n_got; k++) begin
            chk({tag, " left"},  got_l[k], ext(tv_l[k], n));
            chk({tag, " right"}, got_r[k], ext(tv_r[k], n));
        end
    endtask

    task automatic load_vecs(input int n);
        if (n == 18) begin
            tv_l[0] = 18'h1FFFF; tv_r[0] = 18'h20000;
            tv_l[1] = 18'h2A5C3; tv_r[1] = 18'h15A3C;
            tv_l[2] = 18'h00001; tv_r[2] = 18'h3FFFF;
        end else begin
            tv_l[0] = 18'h38000; tv_r[0] = 18'h07FFF;
            tv_l[1] = 18'h0A5C3; tv_r[1] = 18'h01234;
            tv_l[2] = 18'h0FFFF; tv_r[2] = 18'h00001;
        end
    endtask

    // Standard framings (I2S, left- and right-aligned).
    task automatic t_std(input string tag, input int fm, input int n, input int slot);
        logic L;
        L = (fm == 0) ? 1'b0 : 1'b1;
        load_vecs(n);
        do_reset(2'(fm), n == 18, ~L);
        repeat (3) put(~L, 1'b1, 1'b0);
        for (int k = 0; k < 3; k++) begin
            send_slot(fm, n, slot, L,  tv_l[k]);
            send_slot(fm, n, slot, ~L, tv_r[k]);
        end
        if (fm == 2) put(L, 1'b1, 1'b0);
        repeat (3) @(negedge bclk);
        verify(tag, n, 3);
    endtask

    task automatic t_pulse(input string tag, input int n, input int pw, input int pad);
        load_vecs(n);
        do_reset(2'd3, n == 18, 1'b0);
        repeat (3) put(1'b0, 1'b1, 1'b1);
        for (int k = 0; k < 3; k++) begin
            send_pulse_slot(n, pw, pad, tv_l[k]);
            send_pulse_slot(n, pw, pad, tv_r[k]);
        end
        repeat (3) @(negedge bclk);
        verify(tag, n, 3);
    endtask

    task automatic t_reset_state();
        do_reset(2'd1, 1'b1, 1'b0);
        @(negedge bclk);
        chk("R1 valid after reset", 18'(valid_o), 18'd0);
        chk("R1 left after reset",  left_o, 18'd0);
        chk("R1 right after reset", right_o, 18'd0);
    endtask

    // Strobe timing and output hold, left-aligned 16-bit in 16-bit slots.
    task automatic t_strobe();
        load_vecs(16);
        do_reset(2'd1, 1'b0, 1'b0);
        repeat (2) put(1'b0, 1'b1, 1'b0);
        send_slot(1, 16, 16, 1'b1, tv_l[0]);
        send_slot(1, 16, 16, 1'b0, tv_r[0]);
        @(negedge bclk);
        chk("R9 strobe low before LSB processed", 18'(valid_o), 18'd0);
        @(negedge bclk);
        chk("R9 strobe high after LSB edge", 18'(valid_o), 18'd1);
        @(negedge bclk);
        chk("R9 strobe lasts one cycle", 18'(valid_o), 18'd0);
        send_slot(1, 16, 16, 1'b1, tv_l[1]);
        @(negedge bclk);
        chk("R9 left held during next left slot", left_o, ext(tv_l[0], 16));
        chk("R9 right held during next left slot", right_o, ext(tv_r[0], 16));
    endtask

    // Config inputs changed after capture are ignored.
    task automatic t_cfg_frozen();
        load_vecs(18);
        do_reset(2'd1, 1'b1, 1'b0);
        repeat (2) put(1'b0, 1'b1, 1'b0);
        fmt = 2'd0; wlong = 1'b0;
        for (int k = 0; k < 3; k++) begin
            send_slot(1, 18, 24, 1'b1, tv_l[k]);
            send_slot(1, 18, 24, 1'b0, tv_r[k]);
        end
        repeat (3) @(negedge bclk);
        verify("R10 config change ignored", 18, 3);
    endtask

    initial begin
        t_reset_state();
        t_std("R3 R7 left-aligned 18-bit slot 24", 1, 18, 24);
        t_std("R3 R8 left-aligned 16-bit slot 20", 1, 16, 20);
        t_std("R2 R8 I2S 16-bit slot 32", 0, 16, 32);
        t_std("R2 R7 I2S 18-bit slot 19", 0, 18, 19);
        t_std("R5 packed 16-bit slot 16", 2, 16, 16);
        t_std("R4 right-aligned 18-bit slot 24", 2, 18, 24);
        t_std("R4 R8 right-aligned 16-bit slot 32", 2, 16, 32);
        t_pulse("R6 pulse 16-bit", 16, 1, 3);
        t_pulse("R6 R7 pulse 18-bit wide pulse", 18, 2, 0);
        t_strobe();
        t_cfg_frozen();
        finish_up();
    end

endmodule